// File: doc/BRIEF.md
# ADC Conversion Trigger Sequencer

This block is the digital control in front of an analog-to-digital conversion engine. It decides when a conversion begins and when a run of conversions ends. A CPU reaches it through a small register interface. A conversion engine receives a one-cycle start pulse with a latched channel number and answers with a one-cycle done pulse and a 10-bit result. Software can start a conversion by writing a register. Alternatively, an external trigger pin can start conversions. That pin is sampled only on machine-cycle strobes.

Two modes exist. Single mode runs one conversion per trigger. Continuous mode starts the next conversion as soon as the previous one completes. Under external triggering, single mode reacts to a falling edge of the sampled pin. Continuous mode instead runs while the sampled pin is low. A stop always lets the conversion in flight finish. The block keeps a read-only busy flag, a sticky completion interrupt flag, the last result, and one 3-bit channel select that is visible at two register addresses.

The engine interface is a plain pulse pair with no back-pressure. The engine must accept a start whenever one is issued, and it returns exactly one done pulse per start. Results are not streamed out. They are read through registers.

Top module: `adc_trig_seq`

## Requirements
- R1: After reset, the control register reads 0x00, the status register reads 0x00 with the interrupt output low, the channel reads 0, and no start pulse is issued.
- R2: With the external enable (control bit 1) at 0 and the mode bit (control bit 0) at 0, a write to address 2 starts exactly one conversion. The busy bit (control bit 2) reads 1 while it runs and 0 after completion. The result is captured: address 2 holds result bits 7:0 and status bits 7:6 hold result bits 9:8.
- R3: With the mode bit at 1 and the external enable at 0, a write to address 2 starts a chain in which each completion starts the next conversion. Clearing the mode bit stops the chain once the running conversion has completed.
- R4: With the external enable at 1 and the mode bit at 0, one conversion starts when the sampled trigger pin goes from high to low. A write to address 2 then starts nothing.
- R5: The pin is sampled only on cycles where the machine-cycle strobe is high. A low pulse that falls between two strobes starts nothing.
- R6: With both the external enable and the mode bit at 1, conversions repeat while the sampled pin is low. When the pin returns high no new conversion starts, and the one running at that time completes.
- R7: If no conversion has started since reset, external continuous mode needs a sampled falling edge, so a pin held low from reset starts nothing. After any conversion, a sampled low level alone starts it.
- R8: Writing 1 to the busy bit neither sets it nor starts a conversion.
- R9: The interrupt flag (status bit 0, also the interrupt output) is set by every completion. It stays set until a write to address 3 with bit 0 at 0. If a completion coincides with that clear write, the flag stays set.
- R10: The channel is held in one register. Control bits 6:4 and address 1 bits 2:0 both read it, and a write through either address changes what both read.
- R11: A start request while busy is ignored. The channel is latched to the engine at each start, so changing it mid-conversion does not alter the running conversion; the channel appears as result bits 9:7 in the bench's engine model.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_tick | input | 1 | Machine-cycle strobe; the trigger pin is sampled when high |
| trig_pin | input | 1 | External conversion trigger pin |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 channel, 2 result low / software start, 3 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, combinational |
| irq | output | 1 | Sticky conversion-complete request |
| eng_start | output | 1 | One-cycle conversion start pulse to the engine |
| eng_chan | output | 3 | Channel latched at the last start |
| eng_done | input | 1 | One-cycle completion pulse from the engine |
| eng_result | input | 10 | Conversion result, valid with eng_done |

## Verification
The bench builds the block with its default widths: a 3-bit channel and a 10-bit result. It also uses an engine model with a latency of six cycles and a strobe every fourth cycle. With these values several back-to-back continuous conversions fit within a few dozen cycles. They also leave three unsampled cycles between strobes, where a short pin glitch can be placed. Because the engine model folds the latched channel into the result, a channel change during a busy period shows up in the value read back.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  typedef enum logic [1:0] {
    A_CTRL  = 2'd0,
    A_CHAN  = 2'd1,
    A_RESLO = 2'd2,
    A_STAT  = 2'd3
  } reg_addr_e;
  localparam int CTRL_CONT = 0;
  localparam int CTRL_EXT  = 1;
  localparam int CTRL_BUSY = 2;
  localparam int CTRL_CHAN = 4;
  localparam int STAT_IRQ  = 0;
endpackage

// File: rtl/adc_trig_sampler.sv
module adc_trig_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pin,
  output logic fall_o,
  output logic low_o
);
  logic have_q, cur_q, fall_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      cur_q  <= 1'b1;
      fall_q <= 1'b0;
    end else begin
      fall_q <= 1'b0;
      if (tick) begin
        have_q <= 1'b1;
        cur_q  <= pin;
        fall_q <= have_q & cur_q & ~pin;
      end
    end
  end

  assign fall_o = fall_q;
  assign low_o  = have_q & ~cur_q;

  // R5
  fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> $past(tick));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
  parameter int CH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cont,
  input  logic            ext_en,
  input  logic            sw_go,
  input  logic            fall,
  input  logic            low,
  input  logic [CH_W-1:0] chan,
  input  logic            eng_done,
  output logic            busy_o,
  output logic            done_ok_o,
  output logic            eng_start_o,
  output logic [CH_W-1:0] eng_chan_o
);
  logic busy_q, ever_q, start_q;
  logic [CH_W-1:0] chan_q;
  logic ext_req, done_ok, start;

  assign ext_req = ext_en & ((cont & ever_q) ? low : fall);
  assign done_ok = eng_done & busy_q;
  assign start   = (~busy_q & (sw_go | ext_req)) |
                   (done_ok & cont & (~ext_en | low));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      ever_q  <= 1'b0;
      start_q <= 1'b0;
      chan_q  <= '0;
    end else begin
      busy_q  <= start | (busy_q & ~eng_done);
      start_q <= start;
      if (start) begin
        ever_q <= 1'b1;
        chan_q <= chan;
      end
    end
  end

  assign busy_o      = busy_q;
  assign done_ok_o   = done_ok;
  assign eng_start_o = start_q;
  assign eng_chan_o  = chan_q;

  // R11
  start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start_o |-> $past(!busy_q || eng_done));
  // R11
  chan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !eng_start_o) |-> $stable(eng_chan_o));
endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
  import adc_seq_pkg::*;
#(
  parameter int CH_W  = 3,
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             busy,
  input  logic             done_ok,
  input  logic [RES_W-1:0] eng_result,
  output logic             cont_o,
  output logic             ext_o,
  output logic [CH_W-1:0]  chan_o,
  output logic             sw_go_o,
  output logic             irq_o
);
  localparam int HI_W = RES_W - 8;

  logic cont_q, ext_q, irq_q;
  logic [CH_W-1:0]  chan_q;
  logic [RES_W-1:0] res_q;
  logic wr_ctrl, wr_chan, wr_lo, wr_stat, irq_clr;

  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_chan = reg_wr && (reg_addr == A_CHAN);
  assign wr_lo   = reg_wr && (reg_addr == A_RESLO);
  assign wr_stat = reg_wr && (reg_addr == A_STAT);
  assign irq_clr = wr_stat && !reg_wdata[STAT_IRQ];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cont_q <= 1'b0;
      ext_q  <= 1'b0;
      irq_q  <= 1'b0;
      chan_q <= '0;
      res_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        cont_q <= reg_wdata[CTRL_CONT];
        ext_q  <= reg_wdata[CTRL_EXT];
        chan_q <= reg_wdata[CTRL_CHAN +: CH_W];
      end else if (wr_chan) begin
        chan_q <= reg_wdata[CH_W-1:0];
      end
      irq_q <= done_ok | (irq_q & ~irq_clr);
      if (done_ok) res_q <= eng_result;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[CTRL_CONT] = cont_q;
        reg_rdata[CTRL_EXT]  = ext_q;
        reg_rdata[CTRL_BUSY] = busy;
        reg_rdata[CTRL_CHAN +: CH_W] = chan_q;
      end
      A_CHAN:  reg_rdata[CH_W-1:0] = chan_q;
      A_RESLO: reg_rdata = res_q[7:0];
      default: begin
        reg_rdata[STAT_IRQ] = irq_q;
        reg_rdata[7 -: HI_W] = res_q[RES_W-1:8];
      end
    endcase
  end

  assign cont_o  = cont_q;
  assign ext_o   = ext_q;
  assign chan_o  = chan_q;
  assign sw_go_o = wr_lo & ~ext_q;
  assign irq_o   = irq_q;

  // R9
  irq_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_ok |=> irq_o);
  // R10
  chan_alias_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_chan |=> (chan_o == $past(reg_wdata[CH_W-1:0])));
endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq #(
  parameter int CH_W  = 3,
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mc_tick,
  input  logic             trig_pin,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  output logic             irq,
  output logic             eng_start,
  output logic [CH_W-1:0]  eng_chan,
  input  logic             eng_done,
  input  logic [RES_W-1:0] eng_result
);
  logic fall, low, busy, done_ok, cont, ext_en, sw_go;
  logic [CH_W-1:0] chan;

  adc_trig_sampler u_samp (
    .clk(clk), .rst_n(rst_n), .tick(mc_tick), .pin(trig_pin),
    .fall_o(fall), .low_o(low)
  );

  adc_seq_ctrl #(.CH_W(CH_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cont(cont), .ext_en(ext_en), .sw_go(sw_go),
    .fall(fall), .low(low), .chan(chan), .eng_done(eng_done),
    .busy_o(busy), .done_ok_o(done_ok), .eng_start_o(eng_start),
    .eng_chan_o(eng_chan)
  );

  adc_seq_regs #(.CH_W(CH_W), .RES_W(RES_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy),
    .done_ok(done_ok), .eng_result(eng_result), .cont_o(cont),
    .ext_o(ext_en), .chan_o(chan), .sw_go_o(sw_go), .irq_o(irq)
  );
endmodule

// File: tb/adc_trig_seq_tb.sv
module adc_trig_seq_tb;
  localparam int LAT = 6;
  localparam int MC_DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trig_pin = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic irq, eng_start, eng_done;
  logic [2:0] eng_chan;
  logic [9:0] eng_result;
  logic [1:0] div_q;
  logic mc_tick;
  int n_start, n_done, stub_cnt, stub_n;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  always_ff @(posedge clk) begin
    if (!rst_n) div_q <= '0;
    else div_q <= (int'(div_q) == MC_DIV - 1) ? 2'd0 : div_q + 2'd1;
  end
  assign mc_tick = (div_q == 2'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stub_cnt <= 0; stub_n <= 0; eng_done <= 1'b0; eng_result <= '0;
      n_start <= 0; n_done <= 0;
    end else begin
      eng_done <= 1'b0;
      if (eng_done) n_done <= n_done + 1;
      if (eng_start) begin
        n_start <= n_start + 1;
        stub_cnt <= LAT;
        stub_n <= stub_n + 1;
        eng_result <= {eng_chan, 7'(stub_n)};
      end else if (stub_cnt != 0) begin
        stub_cnt <= stub_cnt - 1;
        if (stub_cnt == 1) eng_done <= 1'b1;
      end
    end
  end

  adc_trig_seq u_dut (
    .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .trig_pin(trig_pin),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .eng_start(eng_start),
    .eng_chan(eng_chan), .eng_done(eng_done), .eng_result(eng_result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd0, v); chk(v == 8'h00, "R1 ctrl", v, 0);
    rd(2'd3, v); chk(v == 8'h00 && !irq, "R1 stat", v, 0);
    rd(2'd1, v); chk(v == 8'h00, "R1 chan", v, 0);
    chk(n_start == 0, "R1 starts", n_start, 0);
  endtask

  task automatic t_first_cont;
    logic [7:0] v;
    int s;
    wr(2'd0, 8'h03); idle(40);
    chk(n_start == 0, "R7 held low needs edge", n_start, 0);
    trig_pin = 1'b1; idle(12); trig_pin = 1'b0; idle(40);
    chk(n_start >= 2, "R6 repeats while low", n_start, 2);
    trig_pin = 1'b1; idle(40); s = n_start; idle(40);
    chk(n_start == s, "R6 stops when high", n_start, s);
    chk(n_done == n_start, "R6 running completes", n_done, n_start);
    rd(2'd0, v); chk(v[2] == 1'b0, "R6 idle", v[2], 0);
  endtask

  task automatic t_level;
    int s;
    wr(2'd0, 8'h00); trig_pin = 1'b0; idle(20); s = n_start;
    chk(n_start == s, "R7 ext off", n_start, s);
    wr(2'd0, 8'h03); idle(40);
    chk(n_start > s, "R7 low level starts after prior conversion", n_start, s + 1);
    trig_pin = 1'b1; idle(60); wr(2'd0, 8'h00);
  endtask

  task automatic t_sw_single;
    logic [7:0] v, h;
    int s, e;
    s = n_start;
    wr(2'd1, 8'h05); wr(2'd2, 8'h00); idle(2);
    rd(2'd0, v); chk(v[2] == 1'b1, "R2 busy set", v[2], 1);
    idle(30);
    chk(n_start == s + 1, "R2 one start", n_start, s + 1);
    rd(2'd0, v); chk(v[2] == 1'b0, "R2 busy clear", v[2], 0);
    rd(2'd2, v); rd(2'd3, h);
    e = (5 << 7) | s;
    chk({h[7:6], v} == 10'(e), "R2 result", {h[7:6], v}, e);
  endtask

  task automatic t_busy_ignore;
    logic [7:0] v, h;
    int s;
    s = n_start;
    wr(2'd1, 8'h05); wr(2'd2, 8'h00); idle(1);
    wr(2'd1, 8'h02); wr(2'd2, 8'h00); idle(30);
    chk(n_start == s + 1, "R11 busy request ignored", n_start, s + 1);
    rd(2'd2, v); rd(2'd3, h);
    chk({h[7:6], v[7]} == 3'd5, "R11 channel latched", {h[7:6], v[7]}, 5);
  endtask

  task automatic t_busy_ro;
    logic [7:0] v;
    int s;
    s = n_start;
    wr(2'd0, 8'h04); idle(5);
    rd(2'd0, v); chk(v[2] == 1'b0, "R8 busy read-only", v[2], 0);
    chk(n_start == s, "R8 no start", n_start, s);
  endtask

  task automatic t_sw_cont;
    int s;
    s = n_start;
    wr(2'd0, 8'h01); wr(2'd2, 8'h00); idle(40);
    chk(n_start >= s + 3, "R3 chain runs", n_start, s + 3);
    wr(2'd0, 8'h00); idle(30); s = n_start; idle(30);
    chk(n_start == s, "R3 chain stops", n_start, s);
    chk(n_done == n_start, "R3 last completes", n_done, n_start);
  endtask

  task automatic t_ext_single;
    int s;
    trig_pin = 1'b1; wr(2'd0, 8'h02); idle(12); s = n_start;
    wr(2'd2, 8'h00); idle(30);
    chk(n_start == s, "R4 write ignored", n_start, s);
    @(negedge clk); while (!mc_tick) @(negedge clk);
    @(negedge clk); trig_pin = 1'b0; @(negedge clk); trig_pin = 1'b1;
    idle(30);
    chk(n_start == s, "R5 glitch between strobes", n_start, s);
    trig_pin = 1'b0; idle(12); trig_pin = 1'b1; idle(30);
    chk(n_start == s + 1, "R4 edge starts one", n_start, s + 1);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_irq;
    logic [7:0] v;
    wr(2'd3, 8'h00);
    rd(2'd3, v); chk(v[0] == 1'b0 && !irq, "R9 cleared", v[0], 0);
    wr(2'd2, 8'h00); idle(30);
    rd(2'd3, v); chk(v[0] == 1'b1 && irq, "R9 set on done", v[0], 1);
    wr(2'd3, 8'h01);
    rd(2'd3, v); chk(v[0] == 1'b1, "R9 write 1 keeps", v[0], 1);
    wr(2'd3, 8'h00);
    rd(2'd3, v); chk(v[0] == 1'b0, "R9 write 0 clears", v[0], 0);
    wr(2'd2, 8'h00);
    @(negedge clk); while (!eng_done) @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h00;
    @(negedge clk); reg_wr = 1'b0;
    rd(2'd3, v); chk(v[0] == 1'b1, "R9 completion wins", v[0], 1);
  endtask

  task automatic t_chan;
    logic [7:0] v;
    wr(2'd1, 8'h06);
    rd(2'd0, v); chk(v[6:4] == 3'd6, "R10 alias via ctrl", v[6:4], 6);
    wr(2'd0, 8'h30);
    rd(2'd1, v); chk(v[2:0] == 3'd3, "R10 alias via chan", v[2:0], 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_first_cont;
    t_level;
    t_sw_single;
    t_busy_ignore;
    t_busy_ro;
    t_sw_cont;
    t_ext_single;
    t_irq;
    t_chan;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule